// File: doc/BRIEF.md
# Asynchronous Local Bus Slave Port

This block lets an external processor read and write a register space inside the chip over an asynchronous parallel local bus. The processor is always the master and sends no bus clock. The block runs on an internal clock about three times faster than the bus. Each bus access becomes one single-cycle request on a simple internal register port. Read data returned on that port is driven back onto the bus data lines while the processor holds output enable.

Only one timing strobe crosses into the internal clock domain, through a two-flop synchronizer that presets to the inactive level on reset. The address, direction and data pins are registered into short delay lines with no synchronization of their own. An edge of the synchronized strobe picks the sample to use. The strobe is either chip select alone or, when the pair mode is selected, the union of write enable and output enable, gated by chip select. Writes complete on the strobe's trailing edge, using data taken from three edges back. In the fixed-delay mode they complete instead a set number of cycles after the leading edge.

Top module: `lbus_async_slave`

## Requirements
- R1: After reset, with the bus idle, `reg_wr`, `reg_rd` and `lb_data_oe` stay low and no access is produced.
- R2: The address is captured from `lb_addr` on every clock edge that samples `lb_ale` high. Changes on `lb_addr` while `lb_ale` is low do not alter the address carried by the next request.
- R3: The leading (falling) edge of the synchronized strobe, with `lb_we_n` high, issues exactly one `reg_rd` pulse carrying the captured address. `reg_rdata` is sampled in the cycle of that pulse and is held as the bus read value.
- R4: `lb_data_oe` is high exactly while both `lb_oe_n` and `lb_cs_n` are low, and `lb_data_out` then shows the held read value. Raising `lb_oe_n` releases the bus with no clock edge needed.
- R5: With `cfg_delay_mode` = 0, a write (`lb_we_n` low at the leading edge) issues one `reg_wr` pulse after the trailing edge. Its data is the bus value sampled by the last clock edge before the edge that first samples the strobe inactive. The bus value at the deasserting edge itself is not used.
- R6: With `cfg_delay_mode` = 1 and `DELAY_CNT` = 10, a write issues `reg_wr` in clock cycle DELAY_CNT+3 = 13, counting as cycle 1 the first edge that samples the strobe asserted. The strobe stays asserted throughout.
- R7: With `cfg_delay_mode` = 1, a write whose strobe is released before that count completes produces no request.
- R8: With `cfg_pair_strobes` = 1, each assertion of write enable or output enable is its own access while chip select stays low. With `cfg_pair_strobes` = 0, chip select alone times accesses, so two write-enable pulses inside one chip-select assertion give one write.
- R9: A chip-select pulse lasting a single clock cycle produces at most one request.
- R10: Every request is a one-cycle pulse, and `reg_wr` and `reg_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pair_strobes | input | 1 | 1: write/output enable pair times accesses; 0: chip select |
| cfg_delay_mode | input | 1 | 1: writes complete a fixed count after the leading edge; 0: at the trailing edge |
| lb_cs_n | input | 1 | Bus chip select, active low |
| lb_ale | input | 1 | Address latch enable, high in the address phase |
| lb_we_n | input | 1 | Write enable, active low |
| lb_oe_n | input | 1 | Output enable, active low |
| lb_addr | input | 24 | Bus address |
| lb_data_in | input | 32 | Data from the bus pads |
| lb_data_out | output | 32 | Data to the bus pads |
| lb_data_oe | output | 1 | Pad driver enable for the data lines |
| reg_wr | output | 1 | One-cycle write request |
| reg_rd | output | 1 | One-cycle read request |
| reg_addr | output | 24 | Request address |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid in the cycle `reg_rd` is high |

## Verification
The assertions assume that the master never waits for the slave. Every strobe stays asserted and inactive for several fast cycles, and address and data are settled a few cycles before the trailing edge. The configuration inputs are assumed to change only while the bus is idle. The stimulus drives all pins on the falling clock edge. It changes the mode inputs only between accesses and holds strobes for six or more cycles, except in the deliberate one-cycle glitch and early-release cases. The bench's register port answers reads in the same cycle, from a function of the request address.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  // Strobe that times an access, active low.
  function automatic logic pick_strobe(input logic pair, input logic cs_n,
                                       input logic we_n, input logic oe_n);
    return pair ? (cs_n | (we_n & oe_n)) : cs_n;
  endfunction

  // Falling edge of an active-low strobe: access begins.
  function automatic logic lead_edge(input logic now, input logic prev);
    return !now && prev;
  endfunction

  // Rising edge of an active-low strobe: access ends.
  function automatic logic trail_edge(input logic now, input logic prev);
    return now && !prev;
  endfunction

  // Fixed-delay count has reached its limit.
  function automatic logic count_done(input int unsigned cnt, input int unsigned limit);
    return cnt >= limit;
  endfunction

endpackage

// File: rtl/lbs_sync.sv
module lbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  // Presets to the inactive (high) level so reset creates no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];

  AST_SYNC_FALL_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q) |-> !$past(d, STAGES)); // R1
endmodule

// File: rtl/lbs_delay.sv
module lbs_delay #(
  parameter int            W     = 1,
  parameter int            DEPTH = 1,
  parameter logic [W-1:0]  INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 1) begin : g_one
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= INIT;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_many
      logic [DEPTH-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {DEPTH{INIT}};
        else        stg <= {stg[DEPTH-2:0], d};
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/lbs_ctrl.sv
module lbs_ctrl
  import lbs_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int DELAY_CNT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              delay_mode,
  input  logic              strobe_s,
  input  logic              dir_we_n,
  input  logic [ADDR_W-1:0] addr_hold,
  input  logic [DATA_W-1:0] lag_data,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata
);
  localparam int CNT_W = $clog2(DELAY_CNT + 1);

  logic             strobe_q;
  logic             active;
  logic             is_wr;
  logic [CNT_W-1:0] cnt;

  // Named events for the assertions.
  logic lead_evt, trail_evt, delay_hit;
  assign lead_evt  = lead_edge(strobe_s, strobe_q);
  assign trail_evt = trail_edge(strobe_s, strobe_q);
  assign delay_hit = count_done(int'(cnt), DELAY_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b1;
      active    <= 1'b0;
      is_wr     <= 1'b0;
      cnt       <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      strobe_q <= strobe_s;
      reg_wr   <= 1'b0;
      reg_rd   <= 1'b0;
      if (lead_evt) begin
        active <= 1'b1;
        is_wr  <= !dir_we_n;
        cnt    <= CNT_W'(1);
        if (dir_we_n) begin
          reg_rd   <= 1'b1;
          reg_addr <= addr_hold;
        end
      end else if (active) begin
        if (delay_mode) begin
          if (trail_evt) begin
            active <= 1'b0;               // released early: drop it
          end else if (delay_hit) begin
            active <= 1'b0;
            if (is_wr) begin
              reg_wr    <= 1'b1;
              reg_addr  <= addr_hold;
              reg_wdata <= lag_data;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (trail_evt) begin
          active <= 1'b0;
          if (is_wr) begin
            reg_wr    <= 1'b1;
            reg_addr  <= addr_hold;
            reg_wdata <= lag_data;
          end
        end
      end
    end
  end

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R10
  AST_WR_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)); // R10
  AST_DELAY_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DELAY_CNT); // R6
endmodule

// File: rtl/lbus_async_slave.sv
module lbus_async_slave
  import lbs_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CAPTURE_LAG = 3,
  parameter int DELAY_CNT   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pair_strobes,
  input  logic              cfg_delay_mode,
  input  logic              lb_cs_n,
  input  logic              lb_ale,
  input  logic              lb_we_n,
  input  logic              lb_oe_n,
  input  logic [ADDR_W-1:0] lb_addr,
  input  logic [DATA_W-1:0] lb_data_in,
  output logic [DATA_W-1:0] lb_data_out,
  output logic              lb_data_oe,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int DIR_DEPTH = SYNC_STAGES; // direction aged like the strobe

  logic              strobe_raw, strobe_s;
  logic              ale_q;
  logic [ADDR_W-1:0] addr_q, addr_hold;
  logic              dir_we_n;
  logic [DATA_W-1:0] lag_data;
  logic [DATA_W-1:0] rd_hold;

  assign strobe_raw = pick_strobe(cfg_pair_strobes, lb_cs_n, lb_we_n, lb_oe_n);

  lbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe_raw), .q(strobe_s));

  lbs_delay #(.W(ADDR_W + 1), .DEPTH(1), .INIT('0)) u_addr_dly (
    .clk(clk), .rst_n(rst_n), .d({lb_ale, lb_addr}), .q({ale_q, addr_q}));

  lbs_delay #(.W(1), .DEPTH(DIR_DEPTH), .INIT(1'b1)) u_dir_dly (
    .clk(clk), .rst_n(rst_n), .d(lb_we_n), .q(dir_we_n));

  lbs_delay #(.W(DATA_W), .DEPTH(CAPTURE_LAG), .INIT('0)) u_data_dly (
    .clk(clk), .rst_n(rst_n), .d(lb_data_in), .q(lag_data));

  // Address phase: keep the newest address seen with the latch enable high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_hold <= '0;
    else if (ale_q) addr_hold <= addr_q;
  end

  lbs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DELAY_CNT(DELAY_CNT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .delay_mode(cfg_delay_mode), .strobe_s(strobe_s),
    .dir_we_n(dir_we_n), .addr_hold(addr_hold), .lag_data(lag_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata));

  // Read data returned in the request cycle, held for the bus.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_hold <= '0;
    else if (reg_rd) rd_hold <= reg_rdata;
  end

  assign lb_data_out = rd_hold;
  assign lb_data_oe  = !lb_oe_n && !lb_cs_n;

  AST_RD_AFTER_STROBE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (!$past(strobe_s) && $past(strobe_s, 2))); // R3
  AST_TRAIL_WR_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !$past(cfg_delay_mode)) |-> ($past(strobe_s) && !$past(strobe_s, 2))); // R5
endmodule

// File: tb/tb_lbus_async_slave.sv
`timescale 1ns/1ps
module tb_lbus_async_slave;
  localparam int WD_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_pair_strobes = 1'b0, cfg_delay_mode = 1'b0;
  logic        lb_cs_n = 1'b1, lb_ale = 1'b0, lb_we_n = 1'b1, lb_oe_n = 1'b1;
  logic [23:0] lb_addr = '0;
  logic [31:0] lb_data_in = '0;
  logic [31:0] lb_data_out, reg_wdata, reg_rdata;
  logic        lb_data_oe, reg_wr, reg_rd;
  logic [23:0] reg_addr;

  int checks = 0, errors = 0;
  bit finished = 0;
  int wr_cnt = 0, rd_cnt = 0, overlap = 0, long_pulse = 0;
  logic [23:0] last_waddr, last_raddr;
  logic [31:0] last_wdata;
  logic prev_wr = 0, prev_rd = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] rd_model(input logic [23:0] a);
    return {a[7:0], a} ^ 32'h5A5A_0000;
  endfunction
  assign reg_rdata = rd_model(reg_addr);

  lbus_async_slave dut (
    .clk(clk), .rst_n(rst_n), .cfg_pair_strobes(cfg_pair_strobes),
    .cfg_delay_mode(cfg_delay_mode), .lb_cs_n(lb_cs_n), .lb_ale(lb_ale),
    .lb_we_n(lb_we_n), .lb_oe_n(lb_oe_n), .lb_addr(lb_addr),
    .lb_data_in(lb_data_in), .lb_data_out(lb_data_out), .lb_data_oe(lb_data_oe),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // Request monitor, sampled away from the active edge.
  always @(negedge clk) if (rst_n) begin
    if (reg_wr) begin wr_cnt++; last_waddr = reg_addr; last_wdata = reg_wdata; end
    if (reg_rd) begin rd_cnt++; last_raddr = reg_addr; end
    if (reg_wr && reg_rd) overlap++;
    if ((reg_wr && prev_wr) || (reg_rd && prev_rd)) long_pulse++;
    prev_wr = reg_wr; prev_rd = reg_rd;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [23:0] a);
    lb_ale = 1'b1; lb_addr = a; cyc(3);
    lb_ale = 1'b0; lb_addr = 24'hFFFFFF; cyc(2); // muxed-bus junk, ignored
  endtask

  task automatic t_reset;
    cyc(10);
    check(reg_wr == 0 && reg_rd == 0, "R1 req idle", {30'd0, reg_wr, reg_rd}, 0);
    check(lb_data_oe == 0, "R1 bus released", lb_data_oe, 0);
    check(wr_cnt + rd_cnt == 0, "R1 no access", wr_cnt + rd_cnt, 0);
  endtask

  task automatic t_trail_write(input logic [23:0] a, input logic [31:0] d);
    int w0 = wr_cnt;
    addr_phase(a);
    lb_data_in = d; lb_we_n = 0; lb_cs_n = 0; cyc(8);
    lb_cs_n = 1; lb_we_n = 1; cyc(8);
    check(wr_cnt == w0 + 1, "R5 one write", wr_cnt - w0, 1);
    check(last_waddr == a, "R2 write address", last_waddr, a);
    check(last_wdata == d, "R5 write data", last_wdata, d);
  endtask

  task automatic t_tap;
    int w0 = wr_cnt;
    addr_phase(24'h000123);
    lb_data_in = 32'h1111_1111; lb_we_n = 0; lb_cs_n = 0; cyc(8);
    lb_data_in = 32'h2222_2222; cyc(1);
    lb_data_in = 32'h3333_3333; lb_cs_n = 1; cyc(1);
    lb_we_n = 1; cyc(8);
    check(wr_cnt == w0 + 1, "R5 tap one write", wr_cnt - w0, 1);
    check(last_wdata == 32'h2222_2222, "R5 tap sample", last_wdata, 32'h2222_2222);
  endtask

  task automatic t_read(input logic [23:0] a);
    int r0 = rd_cnt;
    addr_phase(a);
    lb_oe_n = 0; lb_cs_n = 0; cyc(8);
    check(rd_cnt == r0 + 1, "R3 one read", rd_cnt - r0, 1);
    check(last_raddr == a, "R3 read address", last_raddr, a);
    check(lb_data_oe == 1, "R4 drive on", lb_data_oe, 1);
    check(lb_data_out == rd_model(a), "R4 read data", lb_data_out, rd_model(a));
    lb_oe_n = 1; #1;
    check(lb_data_oe == 0, "R4 release", lb_data_oe, 0);
    cyc(1); lb_cs_n = 1; cyc(6);
  endtask

  task automatic t_delay_write;
    int w0 = wr_cnt, n = 0;
    cfg_delay_mode = 1;
    addr_phase(24'h00BEEF);
    lb_data_in = 32'hCAFE_0001; lb_we_n = 0; lb_cs_n = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (reg_wr && n == 0) n = i;
      if (i >= 16 && n != 0) break;
    end
    lb_cs_n = 1; lb_we_n = 1; cyc(8);
    check(n == 13, "R6 write cycle", n, 13);
    check(wr_cnt == w0 + 1, "R6 one write", wr_cnt - w0, 1);
    check(last_wdata == 32'hCAFE_0001, "R6 write data", last_wdata, 32'hCAFE_0001);
    cfg_delay_mode = 0; cyc(2);
  endtask

  task automatic t_delay_abort;
    int w0 = wr_cnt, r0 = rd_cnt;
    cfg_delay_mode = 1; cyc(2);
    lb_data_in = 32'hDEAD_0000; lb_we_n = 0; lb_cs_n = 0; cyc(5);
    lb_cs_n = 1; lb_we_n = 1; cyc(20);
    check(wr_cnt == w0 && rd_cnt == r0, "R7 no request", (wr_cnt - w0) + (rd_cnt - r0), 0);
    cfg_delay_mode = 0; cyc(2);
  endtask

  task automatic t_pair;
    int w0 = wr_cnt, r0 = rd_cnt;
    cfg_pair_strobes = 1; cyc(2);
    lb_cs_n = 0;
    addr_phase(24'h00A001);
    lb_data_in = 32'h0000_AAAA; lb_we_n = 0; cyc(6); lb_we_n = 1; cyc(6);
    addr_phase(24'h00A002);
    lb_oe_n = 0; cyc(6); lb_oe_n = 1; cyc(6);
    lb_cs_n = 1; cyc(4);
    check(wr_cnt == w0 + 1, "R8 pair write", wr_cnt - w0, 1);
    check(last_waddr == 24'h00A001, "R8 pair write addr", last_waddr, 24'h00A001);
    check(rd_cnt == r0 + 1, "R8 pair read", rd_cnt - r0, 1);
    check(last_raddr == 24'h00A002, "R8 pair read addr", last_raddr, 24'h00A002);
    cfg_pair_strobes = 0; cyc(2);
    w0 = wr_cnt;
    lb_we_n = 0; lb_cs_n = 0; cyc(5); lb_we_n = 1; cyc(5);
    lb_we_n = 0; cyc(5); lb_we_n = 1; cyc(5);
    lb_cs_n = 1; cyc(8);
    check(wr_cnt == w0 + 1, "R8 cs mode single", wr_cnt - w0, 1);
  endtask

  task automatic t_glitch;
    int t0 = wr_cnt + rd_cnt;
    lb_we_n = 0; lb_cs_n = 0; cyc(1);
    lb_cs_n = 1; lb_we_n = 1; cyc(12);
    check(wr_cnt + rd_cnt - t0 <= 1, "R9 glitch", wr_cnt + rd_cnt - t0, 1);
  endtask

  initial begin
    #(WD_CYCLES * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1;
    t_reset();
    t_trail_write(24'h012345, 32'h89AB_CDEF);
    t_tap();
    t_read(24'h00C0DE);
    t_read(24'h7FFFFF);
    t_delay_write();
    t_delay_abort();
    t_pair();
    t_glitch();
    check(overlap == 0 && long_pulse == 0, "R10 pulses", overlap + long_pulse, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule